// File: doc/BRIEF.md
# Shared-Period Four-Channel PWM Generator

This block produces four pulse-width-modulated pins that all run at one common period. One prescaler divides the system clock, and one cycle position counter is advanced by the prescaled ticks and shared by every channel. Each channel compares that position against its own 8-bit duty value. A register write port holds the prescaler divisor, the cycle-length select, one byte of per-channel enable and polarity bits, and the four duty values.

Software sets the divisor and the cycle length once, and then changes duty values at any time. A new duty value is held in a per-channel shadow register until the current period ends, so a pulse is never cut short or stretched part-way through. A channel whose enable bit is clear drives a steady level equal to its polarity bit. This lets the pin sit at its idle level without a separate disable control.

Top module: `pwmx_top`

## Requirements
- R1: A divisor register value of 0 selects a prescale of 256 system clocks per tick.
- R2: A divisor value N from 1 to 255 produces one tick every N clocks, so the period is N times the cycle length in clocks.
- R3: When the 255-count cycle is selected, duty 0 keeps an enabled non-inverted pin low for the whole period, and duty 255 keeps it high for the whole period.
- R4: An enabled non-inverted pin goes high at the start of each period and stays high for duty × effective divisor clocks.
- R5: Bit 0 of the cycle-select register chooses the cycle length: 0 selects 256 counts (positions 0..255) and 1 selects 255 counts (positions 0..254). The position returns to 0 on the tick after the last position.
- R6: A channel whose enable bit is clear holds its pin at the value of its polarity bit.
- R7: A set polarity bit inverts an enabled channel, so the pin is low during the active part of the period.
- R8: A duty write reaches the pin only from the next period boundary; the pulse in progress keeps the old duty value.
- R9: Active-low reset clears every register and the counters, and drives all pins low.
- R10: The write port decodes the following addresses: 0 for the divisor, 1 for cycle select, 2 for the mode byte (enable for channel i at bit i, polarity for channel i at bit 4+i), and 4+i for the duty of channel i. Writes to address 3 are ignored. Each pin is registered, so it follows the counter state one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_o | output | 4 | PWM pins, bit i belongs to channel i |

## Verification
A duty write and a period boundary can fall close together, so the shadow register may be loaded in a cycle when the duty register is changing. The bench writes a new duty value in the middle of a running pulse. It then checks that the pulse in progress still has the old width and that the following pulse has the new width. A reference model that is updated every clock is compared on every cycle, so writes to the divisor and the mode byte in the middle of a period are also judged. This includes the cycle where a divisor change meets a tick.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned MAX_CH    = 4;
  localparam int unsigned POS_W     = DATA_W;
  localparam int unsigned DIVEFF_W  = DATA_W + 1;

  localparam logic [ADDR_W-1:0] A_DIV   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CSEL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DUTY0 = 3'd4;

  localparam logic [POS_W-1:0] LAST_SHORT = 8'd254;
  localparam logic [POS_W-1:0] LAST_LONG  = 8'd255;
endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
  import pwmx_pkg::*;
#(
  parameter int unsigned CH_N = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            div_q,
  output logic                         sel255_q,
  output logic [CH_N-1:0]              en_q,
  output logic [CH_N-1:0]              pol_q,
  output logic [CH_N-1:0][DATA_W-1:0]  duty_q
);
  logic [DATA_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      sel255_q <= 1'b0;
      mode_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_DIV:   div_q    <= wr_data;
        A_CSEL:  sel255_q <= wr_data[0];
        A_MODE:  mode_q   <= wr_data;
        default: ;
      endcase
    end
  end

  assign en_q  = mode_q[CH_N-1:0];
  assign pol_q = mode_q[MAX_CH+CH_N-1:MAX_CH];

  for (genvar i = 0; i < CH_N; i++) begin : g_duty
    localparam logic [ADDR_W-1:0] MY_ADDR = A_DUTY0 + ADDR_W'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        duty_q[i] <= '0;
      else if (wr_en && wr_addr == MY_ADDR)
        duty_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/pwmx_prescaler.sv
module pwmx_prescaler
  import pwmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] div_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              tick_o
);
  logic [DIVEFF_W-1:0] div_eff;
  logic [DATA_W-1:0]   cnt_q;

  assign div_eff = (div_i == '0) ? DIVEFF_W'(256) : {1'b0, div_i};
  assign tick_o  = ({1'b0, cnt_q} >= (div_eff - DIVEFF_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DATA_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwmx_cycle.sv
module pwmx_cycle
  import pwmx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             sel255_i,
  output logic [POS_W-1:0] pos_o,
  output logic             wrap_o
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] last;

  assign last   = sel255_i ? LAST_SHORT : LAST_LONG;
  assign wrap_o = tick_i && (pos_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (wrap_o) pos_q <= '0;
    else if (tick_i) pos_q <= pos_q + POS_W'(1);
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/pwmx_channel.sv
module pwmx_channel
  import pwmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [DATA_W-1:0] duty_i,
  input  logic              en_i,
  input  logic              pol_i,
  output logic [DATA_W-1:0] shadow_o,
  output logic              pin_o
);
  logic [DATA_W-1:0] shadow_q;
  logic              active;
  logic              pin_q;

  assign active = (pos_i < shadow_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pin_q    <= 1'b0;
    end else begin
      if (wrap_i) shadow_q <= duty_i;
      pin_q <= en_i ? (active ^ pol_i) : pol_i;
    end
  end

  assign shadow_o = shadow_q;
  assign pin_o    = pin_q;
endmodule

// File: rtl/pwmx_top.sv
module pwmx_top
  import pwmx_pkg::*;
#(
  parameter int unsigned CH_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [CH_N-1:0]   pwm_o
);
  logic [DATA_W-1:0]               div_q;
  logic                            sel255;
  logic [CH_N-1:0]                 en;
  logic [CH_N-1:0]                 pol;
  logic [CH_N-1:0][DATA_W-1:0]     duty;
  logic [CH_N-1:0][DATA_W-1:0]     shadow;
  logic [DATA_W-1:0]               presc_cnt;
  logic                            tick;
  logic [POS_W-1:0]                pos;
  logic                            wrap;

  pwmx_regs #(.CH_N(CH_N)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .div_q(div_q), .sel255_q(sel255),
    .en_q(en), .pol_q(pol), .duty_q(duty)
  );

  pwmx_prescaler presc_i (
    .clk(clk), .rst_n(rst_n), .div_i(div_q), .cnt_o(presc_cnt), .tick_o(tick)
  );

  pwmx_cycle cyc_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sel255_i(sel255),
    .pos_o(pos), .wrap_o(wrap)
  );

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    pwmx_channel ch_i (
      .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .pos_i(pos),
      .duty_i(duty[i]), .en_i(en[i]), .pol_i(pol[i]),
      .shadow_o(shadow[i]), .pin_o(pwm_o[i])
    );
  end
endmodule

// File: rtl/pwmx_checker.sv
module pwmx_checker #(
  parameter int unsigned CH_N = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [7:0]             presc_cnt,
  input logic                   tick,
  input logic [7:0]             pos,
  input logic                   wrap,
  input logic                   sel255,
  input logic [CH_N-1:0]        en,
  input logic [CH_N-1:0]        pol,
  input logic [CH_N-1:0][7:0]   shadow,
  input logic [CH_N-1:0]        pwm_o
);
  AST_PRESC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> presc_cnt == 8'd0);                                   // R2
  AST_PRESC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> presc_cnt == $past(presc_cnt) + 8'd1);               // R1
  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pos == 8'd0);                                         // R5
  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> pos == $past(pos) + 8'd1);                 // R5

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |=> pwm_o[i] == $past(pol[i]));                       // R6
    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      (sel255 && pos <= 8'd254 && shadow[i] == 8'hFF && en[i] && !pol[i])
      |=> pwm_o[i]);                                               // R3
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(shadow[i]));                               // R8
  end
endmodule

bind pwmx_top pwmx_checker #(.CH_N(CH_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .presc_cnt(presc_cnt), .tick(tick),
  .pos(pos), .wrap(wrap), .sel255(sel255), .en(en), .pol(pol),
  .shadow(shadow), .pwm_o(pwm_o)
);

// File: tb/pwmx_top_tb_top.sv
`timescale 1ns/1ps
module pwmx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] pwm_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwmx_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o)
  );

  // behavioural reference model
  int m_div, m_sel, m_mode, m_cnt, m_pos;
  int m_duty[4];
  int m_sh[4];
  bit m_out[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_sel = 0; m_mode = 0; m_cnt = 0; m_pos = 0;
      for (int c = 0; c < 4; c++) begin m_duty[c] = 0; m_sh[c] = 0; m_out[c] = 0; end
    end else begin
      int deff, last;
      for (int c = 0; c < 4; c++) begin
        bit act, e, p;
        act = (m_pos < m_sh[c]);
        e = m_mode[c];
        p = m_mode[4 + c];
        m_out[c] = e ? (act ^ p) : p;
      end
      deff = (m_div == 0) ? 256 : m_div;
      last = m_sel ? 254 : 255;
      if (m_cnt >= deff - 1) begin
        m_cnt = 0;
        if (m_pos >= last) begin
          m_pos = 0;
          for (int c = 0; c < 4; c++) m_sh[c] = m_duty[c];
        end else m_pos++;
      end else m_cnt++;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_div = wr_data;
          3'd1: m_sel = wr_data[0];
          3'd2: m_mode = wr_data;
          3'd4, 3'd5, 3'd6, 3'd7: m_duty[wr_addr - 4] = wr_data;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 4; c++) begin
        checks++;
        if (pwm_o[c] !== m_out[c]) begin
          errors++;
          $display("FAIL R4 cycle model ch%0d cyc %0d: actual %0b expected %0b",
                   c, cyc, pwm_o[c], m_out[c]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(int ch);
    logic p;
    do begin p = pwm_o[ch]; @(negedge clk); end while (!(!p && pwm_o[ch]));
  endtask

  task automatic meas(int ch, output int hi, output int per);
    logic p;
    wait_rise(ch);
    hi = 0; per = 0;
    do begin
      if (pwm_o[ch]) hi++;
      per++;
      p = pwm_o[ch];
      @(negedge clk);
    end while (!(!p && pwm_o[ch]));
  endtask

  task automatic meas_hi(int ch, output int hi);
    wait_rise(ch);
    hi = 0;
    while (pwm_o[ch]) begin hi++; @(negedge clk); end
  endtask

  task automatic hold_level(int ch, bit lvl, int n, string req);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_o[ch] !== lvl) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    int hi, per;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(pwm_o == 4'b0000, "R9 reset pins low", pwm_o, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1: divisor 0 -> 256 clocks per tick, duty 1 -> 256 clocks high
    wr(3'd1, 8'h01);
    wr(3'd4, 8'd1);
    wr(3'd2, 8'h01);
    meas_hi(0, hi);
    chk(hi == 256, "R1 div0 high time", hi, 256);

    // R2 R4 R10: divisor 3, 255-count cycle
    wr(3'd0, 8'd3);
    wr(3'd4, 8'd10);
    wr(3'd5, 8'd0);
    wr(3'd6, 8'd255);
    wr(3'd7, 8'd100);
    wr(3'd3, 8'hFF);   // R10: unused address, no effect
    wr(3'd2, 8'h0F);
    meas(0, hi, per);
    chk(per == 765, "R2 period div3 255", per, 765);
    chk(hi == 30, "R4 high ch0 duty10", hi, 30);
    meas_hi(3, hi);
    chk(hi == 300, "R4 high ch3 duty100", hi, 300);
    hold_level(1, 1'b0, 765, "R3 duty0 low all period");
    hold_level(2, 1'b1, 765, "R3 duty255 high all period");

    // R5: 256-count cycle
    wr(3'd1, 8'h00);
    meas(0, hi, per);
    chk(per == 768, "R5 period 256 counts", per, 768);
    meas(2, hi, per);
    chk(hi == 765, "R5 duty255 in 256 mode", hi, 765);

    // R7: inverted ch0
    wr(3'd2, 8'h1F);
    meas(0, hi, per);
    chk(hi == 738, "R7 inverted high time", hi, 738);
    chk(per == 768, "R7 inverted period", per, 768);

    // R6: disabled channels rest at polarity
    wr(3'd2, 8'h1E);
    repeat (2) @(negedge clk);
    hold_level(0, 1'b1, 800, "R6 disabled pol1 high");
    wr(3'd2, 8'h07);
    repeat (2) @(negedge clk);
    hold_level(3, 1'b0, 800, "R6 disabled pol0 low");

    // R8: duty write during a pulse is deferred
    wr(3'd1, 8'h01);
    wr(3'd2, 8'h0F);
    meas(0, hi, per);
    wait_rise(0);
    hi = 0;
    fork
      begin
        while (pwm_o[0]) begin hi++; @(negedge clk); end
      end
      begin
        repeat (3) @(negedge clk);
        wr(3'd4, 8'd20);
      end
    join
    chk(hi == 30, "R8 pulse in progress keeps old duty", hi, 30);
    meas_hi(0, hi);
    chk(hi == 60, "R8 next pulse uses new duty", hi, 60);

    // R9: reset in mid-run clears everything
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(pwm_o == 4'b0000, "R9 pins low in reset", pwm_o, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    hold_level(0, 1'b0, 300, "R9 ch0 low after reset");
    hold_level(2, 1'b0, 300, "R9 ch2 low after reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule